// File: doc/BRIEF.md
# Frame and histogram slot coordinator

This block sits between the colour pipeline and the memory write path of a video capture chain. It takes a video frame on one AXI4-Stream input and the histogram that was computed over that same frame on a second AXI4-Stream input. It joins the two into one output packet per frame: all frame beats first, then all histogram beats. The output feeds a FIFO that writes into external memory.

External memory is split into a ring of frame slots. The block gives the writer the base address of the slot now being filled. It gives the reader the base address and byte count of the oldest filled slot. Each histogram is stored directly behind its own frame, so the statistics a host reads always belong to the frame it reads with them, however many frames are waiting in the ring.

Image size and histogram size are runtime inputs in bytes. Memory addresses count 16-bit words. A slot is handed to the read side only when both its frame and its histogram arrived intact. When the ring is full, new frames are dropped whole and counted.

Top module: `frame_hist_coord`

## Requirements
- R1: Each accepted frame leaves on the output stream as its frame beats followed by its histogram beats. Frame beats leave with out_tlast_o = 0. Histogram beats carry the histogram input's tlast. Nothing else reaches the output.
- R2: On forwarded frame beats, out_tdata_o bits 31:24 (the alpha byte) are forced to 0xFF, and bits 23:0 (the colour bytes) equal the input.
- R3: A frame starts only on a video beat with vid_tuser_i = 1. While the block waits for a frame, video beats without tuser are consumed and produce no output.
- R4: A frame is img_bytes_i/4 beats long. If the beat at that count has tlast, the histogram phase follows. If that beat lacks tlast, the frame is discarded. A tuser beat that arrives before the count is reached discards the partial frame and starts a new one. A discarded frame commits no slot and takes no histogram.
- R5: The histogram phase takes hist_bytes_i/4 beats, and vid_tready_o is 0 throughout it. The slot is committed only if the beat at that count carries tlast. A tlast that comes earlier ends the phase with no commit.
- R6: The base of slot k is k*(img_bytes_i+hist_bytes_i)/2 words. wr_base_o changes only when a slot is committed.
- R7: rd_valid_o is 1 while at least one slot is committed and unread. rd_base_o is the base of the oldest such slot. rd_bytes_o = img_bytes_i + hist_bytes_i. A pulse on rd_release_i frees that slot. A pulse while the ring is empty has no effect.
- R8: If all SLOTS slots are committed and unread when a frame starts, that frame and its histogram are consumed with no output, and drop_cnt_o rises by one.
- R9: The write and read slot indices wrap modulo SLOTS, so after the last slot the base returns to 0.
- R10: The histogram size is a runtime input. A full 768-byte histogram (192 beats) is handled the same way as a short one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| img_bytes_i | input | SIZE_W | Image size in bytes, a multiple of 4 |
| hist_bytes_i | input | SIZE_W | Histogram size in bytes, a multiple of 4 |
| vid_tdata_i | input | DATA_W | Video pixel, alpha byte in bits 31:24 |
| vid_tuser_i | input | 1 | Start of frame |
| vid_tlast_i | input | 1 | End of line |
| vid_tvalid_i | input | 1 | Video beat valid |
| vid_tready_o | output | 1 | Video beat accepted |
| hst_tdata_i | input | DATA_W | Histogram data |
| hst_tlast_i | input | 1 | Last histogram beat |
| hst_tvalid_i | input | 1 | Histogram beat valid |
| hst_tready_o | output | 1 | Histogram beat accepted |
| out_tdata_o | output | DATA_W | Merged stream data |
| out_tlast_o | output | 1 | End of slot packet |
| out_tvalid_o | output | 1 | Merged beat valid |
| out_tready_i | input | 1 | Downstream ready |
| wr_base_o | output | ADDR_W | Word base of the slot being written |
| rd_valid_o | output | 1 | A committed slot is available |
| rd_base_o | output | ADDR_W | Word base of the oldest committed slot |
| rd_bytes_o | output | SIZE_W+1 | Bytes to read for that slot |
| rd_release_i | input | 1 | Frees the oldest committed slot |
| drop_cnt_o | output | DROP_W | Count of frames dropped on a full ring |

## Verification
The hardest state to reach is a full ring at the moment a start-of-frame beat arrives. The drop decision has to use the occupancy as it stands after any commit in the same cycle, and the dropped frame's histogram must still be consumed silently. The stimulus fills the ring with directed frames and sends one more frame. A random phase then mixes frames, releases, late and truncated frames, and cut histograms, so the full condition comes up again at varying ring positions under random backpressure. A bench model of occupancy and slot indices predicts every base address, the drop count and the exact beat sequence on the output.

// File: rtl/fhc_pkg.sv
package fhc_pkg;
  typedef enum logic [1:0] {PH_WAIT, PH_FRAME, PH_HIST} phase_e;
  localparam logic [7:0] ALPHA_OPAQUE = 8'hFF;
endpackage

// File: rtl/fhc_seq.sv
module fhc_seq
  import fhc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SIZE_W = 26,
  parameter int unsigned DROP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SIZE_W-1:0] fbeats_i,
  input  logic [SIZE_W-1:0] hbeats_i,
  input  logic              full_i,
  input  logic [DATA_W-1:0] vid_tdata_i,
  input  logic              vid_tuser_i,
  input  logic              vid_tlast_i,
  input  logic              vid_tvalid_i,
  output logic              vid_tready_o,
  input  logic [DATA_W-1:0] hst_tdata_i,
  input  logic              hst_tlast_i,
  input  logic              hst_tvalid_i,
  output logic              hst_tready_o,
  output logic [DATA_W-1:0] out_tdata_o,
  output logic              out_tlast_o,
  output logic              out_tvalid_o,
  input  logic              out_tready_i,
  output logic              commit_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  localparam int unsigned COLOR_W = DATA_W - 8;
  localparam logic [SIZE_W-1:0] CNT_ONE = SIZE_W'(1);
  localparam logic [DROP_W-1:0] DROP_ONE = DROP_W'(1);

  phase_e            phase_q;
  logic              skip_q;
  logic [SIZE_W-1:0] cnt_q;
  logic              beat_skip, frame_beat, vid_fire, hst_fire;
  logic              frame_end, hist_end;
  logic [SIZE_W-1:0] idx;
  logic              unused_alpha;

  assign unused_alpha = ^vid_tdata_i[DATA_W-1:COLOR_W];

  always_comb begin
    beat_skip  = 1'b1;
    frame_beat = 1'b0;
    case (phase_q)
      PH_WAIT: begin
        frame_beat = vid_tuser_i;
        beat_skip  = vid_tuser_i ? full_i : 1'b1;
      end
      PH_FRAME: begin
        frame_beat = 1'b1;
        beat_skip  = vid_tuser_i ? full_i : skip_q;
      end
      default: ;
    endcase
    vid_tready_o = (phase_q != PH_HIST) && (beat_skip || out_tready_i);
    hst_tready_o = (phase_q == PH_HIST) && (skip_q || out_tready_i);
    if (phase_q == PH_HIST) begin
      out_tvalid_o = hst_tvalid_i && !skip_q;
      out_tdata_o  = hst_tdata_i;
      out_tlast_o  = hst_tlast_i;
    end else begin
      out_tvalid_o = vid_tvalid_i && !beat_skip;
      out_tdata_o  = {ALPHA_OPAQUE, vid_tdata_i[COLOR_W-1:0]};
      out_tlast_o  = 1'b0;
    end
    vid_fire  = vid_tvalid_i && vid_tready_o && frame_beat;
    hst_fire  = hst_tvalid_i && hst_tready_o;
    // a start-of-frame beat always sits at index 0, restarting any partial frame
    idx       = vid_tuser_i ? '0 : cnt_q;
    frame_end = (idx == fbeats_i - CNT_ONE);
    hist_end  = (cnt_q == hbeats_i - CNT_ONE);
    // combinational so a start-of-frame in the next cycle sees the new occupancy
    commit_o  = hst_fire && !skip_q && hist_end && hst_tlast_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_WAIT;
      skip_q     <= 1'b0;
      cnt_q      <= '0;
      drop_cnt_o <= '0;
    end else if (vid_fire) begin
      if (vid_tuser_i) begin
        skip_q <= full_i;
        if (full_i) drop_cnt_o <= drop_cnt_o + DROP_ONE;
      end
      if (frame_end) begin
        phase_q <= vid_tlast_i ? PH_HIST : PH_WAIT;
        cnt_q   <= '0;
      end else begin
        phase_q <= PH_FRAME;
        cnt_q   <= idx + CNT_ONE;
      end
    end else if (hst_fire) begin
      if (hist_end || hst_tlast_i) begin
        phase_q <= PH_WAIT;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_ONE;
      end
    end
  end
endmodule

// File: rtl/fhc_ptr.sv
module fhc_ptr #(
  parameter int unsigned SLOTS  = 5,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] stride_i,
  output logic [ADDR_W-1:0] base_o
);
  localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SLOTS - 1);
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      base_o <= '0;
    end else if (step_i) begin
      if (idx_q == IDX_LAST) begin
        idx_q  <= '0;
        base_o <= '0;
      end else begin
        idx_q  <= idx_q + IDX_ONE;
        base_o <= base_o + stride_i;
      end
    end
  end
endmodule

// File: rtl/fhc_ring.sv
module fhc_ring #(
  parameter int unsigned SLOTS  = 5,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OCC_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic              commit_i,
  input  logic              release_i,
  output logic [OCC_W-1:0]  occ_o,
  output logic              full_o,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] wr_base_o,
  output logic [ADDR_W-1:0] rd_base_o
);
  localparam logic [OCC_W-1:0] OCC_MAX = OCC_W'(SLOTS);
  localparam logic [OCC_W-1:0] OCC_ONE = OCC_W'(1);

  logic              rel;
  logic [1:0]        steps;
  logic [ADDR_W-1:0] bases [2];

  assign rel        = release_i && (occ_o != '0);
  assign full_o     = (occ_o == OCC_MAX);
  assign rd_valid_o = (occ_o != '0);
  assign steps      = {rel, commit_i};
  assign wr_base_o  = bases[0];
  assign rd_base_o  = bases[1];

  for (genvar g = 0; g < 2; g++) begin : g_ptr
    fhc_ptr #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_ptr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .step_i  (steps[g]),
      .stride_i(stride_i),
      .base_o  (bases[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_o <= '0;
    end else begin
      case ({commit_i, rel})
        2'b10:   occ_o <= occ_o + OCC_ONE;
        2'b01:   occ_o <= occ_o - OCC_ONE;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/frame_hist_coord.sv
module frame_hist_coord #(
  parameter int unsigned SLOTS  = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SIZE_W = 26,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DROP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SIZE_W-1:0] img_bytes_i,
  input  logic [SIZE_W-1:0] hist_bytes_i,
  input  logic [DATA_W-1:0] vid_tdata_i,
  input  logic              vid_tuser_i,
  input  logic              vid_tlast_i,
  input  logic              vid_tvalid_i,
  output logic              vid_tready_o,
  input  logic [DATA_W-1:0] hst_tdata_i,
  input  logic              hst_tlast_i,
  input  logic              hst_tvalid_i,
  output logic              hst_tready_o,
  output logic [DATA_W-1:0] out_tdata_o,
  output logic              out_tlast_o,
  output logic              out_tvalid_o,
  input  logic              out_tready_i,
  output logic [ADDR_W-1:0] wr_base_o,
  output logic              rd_valid_o,
  output logic [ADDR_W-1:0] rd_base_o,
  output logic [SIZE_W:0]   rd_bytes_o,
  input  logic              rd_release_i,
  output logic [DROP_W-1:0] drop_cnt_o
);
  localparam int unsigned OCC_W = $clog2(SLOTS + 1);

  logic [SIZE_W:0]   slot_bytes;
  logic [ADDR_W-1:0] stride;
  logic [SIZE_W-1:0] fbeats, hbeats;
  logic              commit, full;
  logic [OCC_W-1:0]  occ;

  assign slot_bytes = {1'b0, img_bytes_i} + {1'b0, hist_bytes_i};
  assign stride     = ADDR_W'(slot_bytes >> 1);
  assign fbeats     = img_bytes_i >> 2;
  assign hbeats     = hist_bytes_i >> 2;
  assign rd_bytes_o = slot_bytes;

  fhc_seq #(.DATA_W(DATA_W), .SIZE_W(SIZE_W), .DROP_W(DROP_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fbeats_i    (fbeats),
    .hbeats_i    (hbeats),
    .full_i      (full),
    .vid_tdata_i (vid_tdata_i),
    .vid_tuser_i (vid_tuser_i),
    .vid_tlast_i (vid_tlast_i),
    .vid_tvalid_i(vid_tvalid_i),
    .vid_tready_o(vid_tready_o),
    .hst_tdata_i (hst_tdata_i),
    .hst_tlast_i (hst_tlast_i),
    .hst_tvalid_i(hst_tvalid_i),
    .hst_tready_o(hst_tready_o),
    .out_tdata_o (out_tdata_o),
    .out_tlast_o (out_tlast_o),
    .out_tvalid_o(out_tvalid_o),
    .out_tready_i(out_tready_i),
    .commit_o    (commit),
    .drop_cnt_o  (drop_cnt_o)
  );

  fhc_ring #(.SLOTS(SLOTS), .ADDR_W(ADDR_W), .OCC_W(OCC_W)) u_ring (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stride_i  (stride),
    .commit_i  (commit),
    .release_i (rd_release_i),
    .occ_o     (occ),
    .full_o    (full),
    .rd_valid_o(rd_valid_o),
    .wr_base_o (wr_base_o),
    .rd_base_o (rd_base_o)
  );
endmodule

// File: rtl/fhc_chk.sv
module fhc_chk #(
  parameter int unsigned SLOTS  = 5,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DROP_W = 16,
  parameter int unsigned OCC_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vid_tready_i,
  input logic              hst_tready_i,
  input logic              out_tvalid_i,
  input logic [7:0]        alpha_i,
  input logic [OCC_W-1:0]  occ_i,
  input logic              commit_i,
  input logic              rd_release_i,
  input logic [ADDR_W-1:0] wr_base_i,
  input logic [ADDR_W-1:0] rd_base_i,
  input logic [DROP_W-1:0] drop_cnt_i
);
  // R5
  video_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hst_tready_i |-> !vid_tready_i);

  // R2
  alpha_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_tvalid_i && vid_tready_i) |-> (alpha_i == 8'hFF));

  // R8
  no_overfill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_i <= OCC_W'(SLOTS));

  // R6
  wr_base_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(wr_base_i));

  // R7
  rd_base_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_release_i |=> $stable(rd_base_i));

  // R8
  drop_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_cnt_i - $past(drop_cnt_i)) <= DROP_W'(1));
endmodule

bind frame_hist_coord fhc_chk #(
  .SLOTS(SLOTS), .ADDR_W(ADDR_W), .DROP_W(DROP_W), .OCC_W(OCC_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .vid_tready_i(vid_tready_o),
  .hst_tready_i(hst_tready_o),
  .out_tvalid_i(out_tvalid_o),
  .alpha_i     (out_tdata_o[DATA_W-1:DATA_W-8]),
  .occ_i       (occ),
  .commit_i    (commit),
  .rd_release_i(rd_release_i),
  .wr_base_i   (wr_base_o),
  .rd_base_i   (rd_base_o),
  .drop_cnt_i  (drop_cnt_o)
);

// File: tb/frame_hist_coord_test.sv
module frame_hist_coord_test;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 5;

  logic        clk = 0, rst_n = 0;
  logic [25:0] img_bytes, hist_bytes;
  logic [31:0] vid_tdata = 0, hst_tdata = 0;
  logic        vid_tuser = 0, vid_tlast = 0, vid_tvalid = 0;
  logic        hst_tlast = 0, hst_tvalid = 0;
  logic        vid_tready, hst_tready;
  logic [31:0] out_tdata;
  logic        out_tlast, out_tvalid;
  logic        out_tready = 1;
  logic [31:0] wr_base, rd_base;
  logic        rd_valid;
  logic [26:0] rd_bytes;
  logic        rd_release = 0;
  logic [15:0] drop_cnt;

  int checks = 0, errors = 0;
  int img_w = 4, img_h = 3, hbeats = 4;
  int occ_m = 0, wr_m = 0, rd_m = 0, drops_m = 0;
  logic [32:0] exp_q[$];
  logic [32:0] exp_beat;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign img_bytes  = 26'(img_w * img_h * 4);
  assign hist_bytes = 26'(hbeats * 4);

  frame_hist_coord #(.SLOTS(SLOTS)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .img_bytes_i(img_bytes), .hist_bytes_i(hist_bytes),
    .vid_tdata_i(vid_tdata), .vid_tuser_i(vid_tuser), .vid_tlast_i(vid_tlast),
    .vid_tvalid_i(vid_tvalid), .vid_tready_o(vid_tready),
    .hst_tdata_i(hst_tdata), .hst_tlast_i(hst_tlast),
    .hst_tvalid_i(hst_tvalid), .hst_tready_o(hst_tready),
    .out_tdata_o(out_tdata), .out_tlast_o(out_tlast),
    .out_tvalid_o(out_tvalid), .out_tready_i(out_tready),
    .wr_base_o(wr_base), .rd_valid_o(rd_valid), .rd_base_o(rd_base),
    .rd_bytes_o(rd_bytes), .rd_release_i(rd_release), .drop_cnt_o(drop_cnt)
  );

  function automatic longint stride_w();
    return longint'((img_w * img_h * 4 + hbeats * 4) / 2);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && out_tvalid && out_tready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1/R3 unexpected output beat: actual %0h expected none", {out_tlast, out_tdata});
      end else begin
        exp_beat = exp_q.pop_front();
        chk("R1/R2 output beat", {out_tlast, out_tdata}, exp_beat);
      end
    end
    if (rst_n && hst_tvalid && hst_tready) chk("R5 video ready in histogram phase", vid_tready, 0);
  end

  always @(posedge clk) begin
    #1 out_tready = ($urandom % 4) != 0;
  end

  task automatic vbeat(input logic [31:0] d, input logic u, input logic l);
    if ($urandom % 3 == 0) begin @(posedge clk); #1; end
    vid_tdata = d; vid_tuser = u; vid_tlast = l; vid_tvalid = 1;
    @(negedge clk);
    while (!vid_tready) @(negedge clk);
    @(posedge clk); #1;
    vid_tvalid = 0; vid_tuser = 0; vid_tlast = 0;
  endtask

  task automatic hbeat(input logic [31:0] d, input logic l);
    if ($urandom % 3 == 0) begin @(posedge clk); #1; end
    hst_tdata = d; hst_tlast = l; hst_tvalid = 1;
    @(negedge clk);
    while (!hst_tready) @(negedge clk);
    @(posedge clk); #1;
    hst_tvalid = 0; hst_tlast = 0;
  endtask

  // mode 0 good, 1 late (no tlast at count), 2 truncated, 3 good frame + cut histogram
  task automatic frame_op(input int mode);
    bit fwd;
    int n, cut;
    logic [31:0] d;
    logic l;
    fwd = occ_m < SLOTS;
    if (!fwd) drops_m++;
    n = (mode == 2) ? 1 + int'($urandom % (img_w * img_h - 1)) : img_w * img_h;
    for (int i = 0; i < n; i++) begin
      d = $urandom;
      l = (i % img_w) == img_w - 1;
      if (mode == 1 && i == n - 1) l = 0;
      if (fwd) exp_q.push_back({1'b0, 8'hFF, d[23:0]});
      vbeat(d, i == 0, l);
    end
    if (mode == 0 || mode == 3) begin
      cut = (mode == 3) ? 1 + int'($urandom % (hbeats - 1)) : hbeats;
      for (int i = 0; i < cut; i++) begin
        d = $urandom;
        if (fwd) exp_q.push_back({i == cut - 1, d});
        hbeat(d, i == cut - 1);
      end
      if (mode == 0 && fwd) begin
        occ_m++;
        wr_m = (wr_m + 1) % SLOTS;
      end
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic check_state(input string tag);
    drain();
    @(negedge clk);
    chk({"R6 R9 wr_base ", tag}, wr_base, wr_m * stride_w());
    chk({"R7 rd_valid ", tag}, rd_valid, occ_m > 0);
    chk({"R8 drop_cnt ", tag}, drop_cnt, drops_m);
    if (occ_m > 0) chk({"R7 rd_base ", tag}, rd_base, rd_m * stride_w());
    @(posedge clk); #1;
  endtask

  task automatic release_slot();
    @(negedge clk);
    if (occ_m > 0) begin
      chk("R7 rd_base before release", rd_base, rd_m * stride_w());
      chk("R7 rd_bytes", rd_bytes, img_w * img_h * 4 + hbeats * 4);
    end else begin
      chk("R7 rd_valid while empty", rd_valid, 0);
    end
    @(posedge clk); #1;
    rd_release = 1;
    @(posedge clk); #1;
    rd_release = 0;
    if (occ_m > 0) begin
      occ_m--;
      rd_m = (rd_m + 1) % SLOTS;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("reset rd_valid", rd_valid, 0);
    chk("reset wr_base", wr_base, 0);
    chk("reset drop_cnt", drop_cnt, 0);
    chk("reset out_tvalid", out_tvalid, 0);
    @(posedge clk); #1;

    // R7: release on empty ring ignored
    release_slot();
    check_state("empty release");

    // R1 R2 R6: one good slot
    frame_op(0);
    check_state("first slot");

    // R3: stray beats before a start of frame
    for (int i = 0; i < 3; i++) vbeat($urandom, 0, i == 2);
    check_state("R3 stray beats");

    // R4: late frame, then truncated frame followed by a good one
    frame_op(1);
    check_state("R4 late frame");
    frame_op(2);
    frame_op(0);
    check_state("R4 truncated frame");

    // R5: histogram cut short
    frame_op(3);
    check_state("R5 cut histogram");

    // R8: fill ring, then one frame too many
    while (occ_m < SLOTS) frame_op(0);
    check_state("R8 full");
    frame_op(0);
    check_state("R8 dropped frame");
    while (occ_m > 0) release_slot();
    check_state("R9 drained");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 6) frame_op(0);
      else if (r < 8) release_slot();
      else if (r == 8) frame_op(1);
      else begin frame_op(2); frame_op(0); end
      if (it % 4 == 0) frame_op(3);
      check_state("random");
    end

    // R10: full-size histogram, change sizes at ring origin only
    while (wr_m != 0) begin
      if (occ_m == SLOTS) release_slot();
      frame_op(0);
    end
    while (occ_m > 0) release_slot();
    check_state("R9 back at origin");
    img_w = 8; img_h = 2; hbeats = 192;
    frame_op(0);
    check_state("R10 768-byte histogram");
    @(negedge clk);
    chk("R10 rd_bytes", rd_bytes, 64 + 768);
    chk("R10 wr_base", wr_base, 416);
    @(posedge clk); #1;
    release_slot();
    check_state("R10 released");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule